// File: doc/BRIEF.md
# Auto-incrementing register write port

This block sits between a small command-processor core and an external register space. The core writes one of three special destinations, and the port turns those writes into requests. Two destinations load the current address. The raw load accepts any value. The checked load first asks an external protection table whether the value is allowed, and is meant for addresses taken from the incoming command stream. The third destination sends a data word to the current address. After each normal register write the address moves on by one, unless the loaded address asked for a fixed target.

The top byte of the loaded address selects the space. A zero top byte means the normal register space. Any other value names a write-only pipe register, and writes to it go out on a separate request bus. Pipe writes may wait for an unbounded time before they are accepted. Some pipe registers carry no data, and a request for one of these is sent as soon as its address is loaded. Each request bus uses a valid/ready handshake. The port raises `busy` while a request is waiting, and the core holds its command until `busy` drops.

Top module: `regwr_port`

## Requirements
- R1: After reset no request is pending on either bus, `busy` is low, `fault` is low and the current address is zero.
- R2: A command with `cmd_dest` = 0 (raw load) is taken without any protection check and sets the current address. A later command with `cmd_dest` = 2 (data) sends one normal register write whose `reg_addr` is bits 17:0 of that address and whose `reg_data` is the data word.
- R3: In the normal space, each accepted data command adds one to the 18-bit register address, so consecutive data words go to consecutive registers.
- R4: When bit 18 of the loaded address is 1, the address does not advance, and every data word goes to the same register. Bit 18 never shows on `reg_addr`.
- R5: `prot_addr` always carries bits 17:0 of `cmd_wdata`. A command with `cmd_dest` = 1 (checked load) behaves like a raw load when `prot_ok` is high.
- R6: A checked load with `prot_ok` low sets `fault`, which stays set until reset. Data commands after it, and a no-data pipe request it would have triggered, send nothing until the next address load that succeeds.
- R7: A nonzero top byte (bits 31:24) in the loaded address sends data commands to the pipe bus with `pipe_sel` equal to that byte and `pipe_nodata` low. No normal register write goes out, and the pipe target does not advance.
- R8: Loading an address whose top byte is marked no-data in `PIPE_NODATA` (0x84 and 0x86 by default) sends one pipe request at once, with `pipe_nodata` high and `pipe_data` zero.
- R9: A pending request keeps its valid, address, selector and data unchanged until ready is seen, and `busy` stays high while it waits.
- R10: A command offered while `busy` is high is not taken. It changes neither the current address nor the requests.
- R11: The 18-bit register address wraps from 0x3FFFF to 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Core writes a special destination this cycle |
| cmd_dest | input | 2 | 0 raw address, 1 checked address, 2 data, 3 ignored |
| cmd_wdata | input | 32 | Value written by the core |
| busy | output | 1 | A request waits for ready; hold the command |
| prot_addr | output | 18 | Address presented to the protection table |
| prot_ok | input | 1 | Protection table allows `prot_addr` |
| fault | output | 1 | Sticky protection fault |
| reg_valid | output | 1 | Normal register write request |
| reg_ready | input | 1 | Register space accepts the request |
| reg_addr | output | 18 | Register address |
| reg_data | output | 32 | Register data |
| pipe_valid | output | 1 | Pipe register write request |
| pipe_ready | input | 1 | Pipe space accepts the request |
| pipe_sel | output | 8 | Pipe register selector (top address byte) |
| pipe_nodata | output | 1 | Request carries no data |
| pipe_data | output | 32 | Pipe register data |

## Verification
Streams of data words follow raw loads, checked loads, fixed-target loads and a load at the top of the address range. These runs separate plain increment, suppressed increment and wrap-around. Pipe-space loads, both with and without data, show whether traffic moves to the other bus and whether the address write alone triggers a request. A protection refusal in the middle of the stream, and commands offered while a request is held, show whether dropped and ignored commands leave any trace. A long run with ready toggling at random on both buses shows that ordering and values survive back-pressure.

// File: rtl/regwr_port.sv
module regwr_port #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RAW = 18,
  parameter int PW = 8,
  parameter logic [(1<<PW)-1:0] PIPE_NODATA = ({{((1<<PW)-1){1'b0}}, 1'b1} << 8'h84)
                                            | ({{((1<<PW)-1){1'b0}}, 1'b1} << 8'h86)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_dest,
  input  logic [AW-1:0]  cmd_wdata,
  output logic           busy,
  output logic [RAW-1:0] prot_addr,
  input  logic           prot_ok,
  output logic           fault,
  output logic           reg_valid,
  input  logic           reg_ready,
  output logic [RAW-1:0] reg_addr,
  output logic [DW-1:0]  reg_data,
  output logic           pipe_valid,
  input  logic           pipe_ready,
  output logic [PW-1:0]  pipe_sel,
  output logic           pipe_nodata,
  output logic [DW-1:0]  pipe_data
);
  localparam logic [1:0] D_RAW  = 2'd0;
  localparam logic [1:0] D_CHK  = 2'd1;
  localparam logic [1:0] D_DATA = 2'd2;
  localparam int SEL_LSB = AW - PW;

  logic [RAW-1:0] low_q;
  logic           noinc_q;
  logic [PW-1:0]  sel_q;
  logic           blocked_q;

  wire           take     = cmd_valid && !busy;
  wire           is_load  = (cmd_dest == D_RAW) || (cmd_dest == D_CHK);
  wire           chk_fail = (cmd_dest == D_CHK) && !prot_ok;
  wire [PW-1:0]  new_sel  = cmd_wdata[AW-1:SEL_LSB];
  wire           load_go  = take && is_load;
  wire           data_go  = take && (cmd_dest == D_DATA) && !blocked_q;
  wire           reg_go   = data_go && (sel_q == '0);
  wire           pdat_go  = data_go && (sel_q != '0);
  wire           pnd_go   = load_go && !chk_fail && (new_sel != '0) && PIPE_NODATA[new_sel];

  assign busy      = (reg_valid && !reg_ready) || (pipe_valid && !pipe_ready);
  assign prot_addr = cmd_wdata[RAW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q     <= '0;
      noinc_q   <= 1'b0;
      sel_q     <= '0;
      blocked_q <= 1'b0;
      fault     <= 1'b0;
    end else begin
      if (load_go) begin
        low_q     <= cmd_wdata[RAW-1:0];
        noinc_q   <= cmd_wdata[RAW];
        sel_q     <= new_sel;
        blocked_q <= chk_fail;
        if (chk_fail) fault <= 1'b1;
      end else if (reg_go && !noinc_q) begin
        low_q <= low_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_valid <= 1'b0;
      reg_addr  <= '0;
      reg_data  <= '0;
    end else if (reg_go) begin
      reg_valid <= 1'b1;
      reg_addr  <= low_q;
      reg_data  <= cmd_wdata;
    end else if (reg_ready) begin
      reg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_valid  <= 1'b0;
      pipe_sel    <= '0;
      pipe_nodata <= 1'b0;
      pipe_data   <= '0;
    end else if (pdat_go || pnd_go) begin
      pipe_valid  <= 1'b1;
      pipe_sel    <= pnd_go ? new_sel : sel_q;
      pipe_nodata <= pnd_go;
      pipe_data   <= pnd_go ? '0 : cmd_wdata;
    end else if (pipe_ready) begin
      pipe_valid <= 1'b0;
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_data)); // R9
  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_valid && !pipe_ready |=> pipe_valid && $stable(pipe_sel) && $stable(pipe_data) && $stable(pipe_nodata)); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R6
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_valid, pipe_valid})); // R7
  AST_PIPE_SEL_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_valid |-> pipe_sel != '0); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(low_q) && $stable(sel_q) && $stable(noinc_q)); // R10
  AST_NODATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_valid && pipe_nodata |-> pipe_data == '0); // R8
endmodule

// File: tb/regwr_port_bench.sv
module regwr_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_dest = 2'd3;
  logic [31:0] cmd_wdata = '0;
  logic        busy;
  logic [17:0] prot_addr;
  logic        prot_ok = 1'b1;
  logic        fault;
  logic        reg_valid;
  logic        reg_ready = 1'b1;
  logic [17:0] reg_addr;
  logic [31:0] reg_data;
  logic        pipe_valid;
  logic        pipe_ready = 1'b1;
  logic [7:0]  pipe_sel;
  logic        pipe_nodata;
  logic [31:0] pipe_data;

  regwr_port u_regwr_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_wdata(cmd_wdata), .busy(busy), .prot_addr(prot_addr), .prot_ok(prot_ok),
    .fault(fault), .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_data(reg_data), .pipe_valid(pipe_valid), .pipe_ready(pipe_ready),
    .pipe_sel(pipe_sel), .pipe_nodata(pipe_nodata), .pipe_data(pipe_data)
  );

  int checks = 0, bad = 0, nreg = 0, npipe = 0;
  bit finished = 0;
  string cur_tag = "R1";

  typedef struct packed { logic [17:0] a; logic [31:0] d; } rexp_t;
  typedef struct packed { logic [7:0] s; logic nd; logic [31:0] d; } pexp_t;
  rexp_t rq[$]; string rtag[$];
  pexp_t pq[$]; string ptag[$];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  bit hold = 0, rnd = 0;
  logic [7:0] lfsr = 8'h5a;
  initial forever begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    reg_ready  = hold ? 1'b0 : (rnd ? lfsr[0] : 1'b1);
    pipe_ready = hold ? 1'b0 : (rnd ? lfsr[2] : 1'b1);
  end

  always @(negedge clk) begin : mon
    rexp_t re; pexp_t pe; string t;
    if (rst_n) begin
      if (reg_valid && reg_ready) begin
        nreg++;
        if (rq.size() == 0) chk(0, cur_tag, "unexpected reg write", {14'd0, reg_addr}, 0);
        else begin
          re = rq.pop_front(); t = rtag.pop_front();
          chk(reg_addr == re.a, t, "reg_addr", {46'd0, reg_addr}, {46'd0, re.a});
          chk(reg_data == re.d, t, "reg_data", {32'd0, reg_data}, {32'd0, re.d});
        end
      end
      if (pipe_valid && pipe_ready) begin
        npipe++;
        if (pq.size() == 0) chk(0, cur_tag, "unexpected pipe write", {56'd0, pipe_sel}, 0);
        else begin
          pe = pq.pop_front(); t = ptag.pop_front();
          chk({pipe_sel, pipe_nodata, pipe_data} == pe, t, "pipe sel/nodata/data",
              {23'd0, pipe_sel, pipe_nodata, pipe_data}, {23'd0, pe});
        end
      end
    end
  end

  task automatic issue(logic [1:0] dst, logic [31:0] w);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_dest = dst; cmd_wdata = w;
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_dest = 2'd3;
  endtask

  task automatic wreg(logic [17:0] a, logic [31:0] d, string tag);
    rq.push_back({a, d}); rtag.push_back(tag);
    issue(2'd2, d);
  endtask

  task automatic wpipe(logic [7:0] s, logic [31:0] d, string tag);
    pq.push_back({s, 1'b0, d}); ptag.push_back(tag);
    issue(2'd2, d);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n0;
    // R1: reset state
    idle(3);
    chk(!reg_valid && !pipe_valid, "R1", "valid after reset", {reg_valid, pipe_valid}, 0);
    chk(!busy && !fault, "R1", "busy/fault after reset", {busy, fault}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    // R1: address starts at zero
    cur_tag = "R1";
    wreg(18'h0, 32'hA0A0_0001, "R1");

    // R2, R3
    cur_tag = "R2";
    issue(2'd0, 32'h0000_1234);
    wreg(18'h01234, 32'h1111_0001, "R2");
    wreg(18'h01235, 32'h1111_0002, "R3");
    wreg(18'h01236, 32'h1111_0003, "R3");

    // R4: bit 18 fixes the target and is not forwarded
    cur_tag = "R4";
    issue(2'd0, 32'h0004_0020);
    wreg(18'h00020, 32'h2222_0001, "R4");
    wreg(18'h00020, 32'h2222_0002, "R4");
    wreg(18'h00020, 32'h2222_0003, "R4");

    // R11: wrap
    cur_tag = "R11";
    issue(2'd0, 32'h0003_FFFF);
    wreg(18'h3FFFF, 32'h3333_0001, "R11");
    wreg(18'h00000, 32'h3333_0002, "R11");

    // R5: protection query and passing checked load
    cur_tag = "R5";
    @(posedge clk); #2; cmd_wdata = 32'hFF01_2345;
    @(negedge clk);
    chk(prot_addr == 18'h12345, "R5", "prot_addr", {46'd0, prot_addr}, 64'h12345);
    prot_ok = 1'b1;
    issue(2'd1, 32'h0000_0400);
    wreg(18'h00400, 32'h4444_0001, "R5");
    wreg(18'h00401, 32'h4444_0002, "R5");
    chk(!fault, "R5", "fault after allowed load", {63'd0, fault}, 0);

    // R6: refused load
    cur_tag = "R6";
    prot_ok = 1'b0;
    issue(2'd1, 32'h0000_0800);
    idle(1);
    chk(fault, "R6", "fault after refused load", {63'd0, fault}, 1);
    n0 = nreg;
    issue(2'd2, 32'h5555_0001);
    issue(2'd2, 32'h5555_0002);
    idle(4);
    chk(nreg == n0, "R6", "writes after refused load", nreg, n0);
    n0 = npipe;
    issue(2'd1, 32'h8600_0000);
    idle(4);
    chk(npipe == n0, "R6", "no-data pipe after refused load", npipe, n0);
    prot_ok = 1'b1;
    issue(2'd0, 32'h0000_0900);
    wreg(18'h00900, 32'h5555_0003, "R6");
    chk(fault, "R6", "fault sticky", {63'd0, fault}, 1);

    // R7: pipe space with data
    cur_tag = "R7";
    n0 = npipe;
    issue(2'd0, 32'h0500_0000);
    idle(3);
    chk(npipe == n0 && !pipe_valid, "R7", "pipe request on data-carrying load", npipe, n0);
    n0 = nreg;
    wpipe(8'h05, 32'h6666_0001, "R7");
    wpipe(8'h05, 32'h6666_0002, "R7");
    idle(3);
    chk(nreg == n0, "R7", "reg writes in pipe space", nreg, n0);

    // R8: no-data pipe registers fire on load
    cur_tag = "R8";
    pq.push_back({8'h84, 1'b1, 32'h0}); ptag.push_back("R8");
    issue(2'd0, 32'h8400_0000);
    pq.push_back({8'h86, 1'b1, 32'h0}); ptag.push_back("R8");
    issue(2'd1, 32'h8600_1234);
    idle(3);
    chk(pq.size() == 0, "R8", "no-data requests pending", pq.size(), 0);

    // R9, R10: hold under back-pressure, ignore commands while busy
    cur_tag = "R9";
    issue(2'd0, 32'h0000_0100);
    hold = 1;
    idle(2);
    wreg(18'h00100, 32'h7777_0001, "R9");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(reg_valid && busy, "R9", "valid/busy held", {reg_valid, busy}, 2'b11);
      chk(reg_addr == 18'h100 && reg_data == 32'h7777_0001, "R9", "held request",
          {14'd0, reg_addr, reg_data}, {14'd0, 18'h100, 32'h7777_0001});
    end
    cur_tag = "R10";
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_dest = 2'd0; cmd_wdata = 32'h0000_0700;
    repeat (3) @(posedge clk);
    #2; cmd_valid = 1'b0; cmd_dest = 2'd3;
    @(negedge clk);
    chk(reg_addr == 18'h100, "R10", "request changed while busy", {46'd0, reg_addr}, 64'h100);
    hold = 0;
    wreg(18'h00101, 32'h7777_0002, "R10");

    // R3: stream under random back-pressure, mixed with pipe traffic
    cur_tag = "R3";
    rnd = 1;
    issue(2'd0, 32'h0000_2000);
    for (int i = 0; i < 20; i++) wreg(18'h02000 + 18'(i), 32'h8800_0000 + i, "R3");
    issue(2'd0, 32'h0900_0000);
    for (int i = 0; i < 6; i++) wpipe(8'h09, 32'h9900_0000 + i, "R7");
    issue(2'd0, 32'h0004_3000);
    for (int i = 0; i < 5; i++) wreg(18'h03000, 32'hAA00_0000 + i, "R4");
    rnd = 0;
    for (int i = 0; i < 100 && (rq.size() != 0 || pq.size() != 0); i++) @(negedge clk);
    chk(rq.size() == 0 && pq.size() == 0, "R3", "expected items left",
        rq.size() + pq.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule